// File: doc/BRIEF.md
# Anger Position and Energy Qualifier

This block turns one set of four photomultiplier samples (channels A, B, C and D) into a qualified singles event. It sums the four samples to get the deposited energy E. It then forms two light-sharing ratios: the vertical ratio (A+B)/E and the horizontal ratio (B+D)/E. Each ratio is quantized to a few bits. The pair of quantized ratios addresses a programmable position table, and the entry read there is the crystal identifier.

The crystal identifier then selects a lower and an upper energy bound from a second programmable table. The event is marked photopeak-valid when E lies inside that per-crystal window. The time value presented with the samples travels through a delay matched to the datapath, so it leaves together with its own event. Sample sets whose sum is zero are discarded before any ratio is formed.

The converters upstream run freely, so the block accepts a new sample set on every clock. It produces at most one event per clock, after a fixed latency of five cycles. Both tables are loaded through one address/data/write-enable port, normally while no samples are flowing.

Top module: `anger_qualifier`

## Requirements
- R1: A sample set accepted in cycle k (inVal high and E = A+B+C+D not zero) yields evtValid high in cycle k+5. A new sample set can be accepted in every cycle.
- R2: A cycle with inVal low, or with inVal high and E equal to zero, produces no event: evtValid is low five cycles later.
- R3: The vertical ratio code is qy = min(63, floor(64*(A+B)/E)) and the horizontal ratio code is qx = min(63, floor(64*(B+D)/E)). evtCrystal equals the position-table entry at address qy*64 + qx.
- R4: evtEnergyOk is high exactly when lo <= E <= hi, where {hi, lo} is the energy-table entry indexed by evtCrystal. lo sits in data bits [13:0] and hi in bits [27:14].
- R5: evtTime equals the inTime value presented together with the accepted sample set.
- R6: evtEnergy equals A+B+C+D of the event's sample set, with the full 14-bit sum.
- R7: While rstN is low, evtValid is low.
- R8: A table write with tblWe high is applied at the clock edge. tblSel 0 writes position-table entry tblAddr with tblData[7:0]. tblSel 1 writes energy-table entry tblAddr[7:0] with tblData[27:0]. Events accepted after the write use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inVal | input | 1 | Sample set present this cycle |
| inA | input | 12 | Channel A sample, unsigned |
| inB | input | 12 | Channel B sample, unsigned |
| inC | input | 12 | Channel C sample, unsigned |
| inD | input | 12 | Channel D sample, unsigned |
| inTime | input | 16 | Time value belonging to the sample set |
| tblWe | input | 1 | Table write enable |
| tblSel | input | 1 | 0 selects the position table, 1 selects the energy table |
| tblAddr | input | 12 | Table entry address |
| tblData | input | 28 | Table write data |
| evtValid | output | 1 | Event present |
| evtCrystal | output | 8 | Decoded crystal identifier |
| evtEnergyOk | output | 1 | Energy lies inside this crystal's window |
| evtEnergy | output | 14 | Energy sum of the event |
| evtTime | output | 16 | Time value aligned with the event |

## Verification
Five sample sets are in flight at once. In a single cycle, the energy window of one event is being read while the position of a younger event is looked up and its ratios are divided. Back-to-back random traffic, with zero-energy and idle cycles scattered through it, exercises this overlap. Each output is judged against a queue of expected events computed in the bench, so any slip between stages shows up as a wrong crystal, a wrong window verdict or a wrong time. Directed cases add a saturated ratio, windows whose bounds equal E exactly, and a position entry rewritten between two events.

// File: rtl/anger_qual_pkg.sv
package anger_qual_pkg;

  // Per-stage load strobes issued by the control to the datapath
  typedef struct packed {
    logic s1Load;
    logic s2Load;
    logic s3Load;
    logic s4Load;
    logic outLoad;
    logic posWr;
    logic engWr;
  } qualStrobe_t;

  localparam int unsigned PIPE_DEPTH = 5;

endpackage

// File: rtl/anger_qual_ctrl.sv
module anger_qual_ctrl
  import anger_qual_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inVal,
  input  logic        eIsZero,
  input  logic        tblWe,
  input  logic        tblSel,
  output qualStrobe_t strobe,
  output logic        evtValid
);

  logic accept;
  logic [PIPE_DEPTH-1:0] stageVal;

  assign accept = inVal && !eIsZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageVal <= '0;
    end else begin
      stageVal <= {stageVal[PIPE_DEPTH-2:0], accept};
    end
  end

  always_comb begin
    strobe.s1Load  = accept;
    strobe.s2Load  = stageVal[0];
    strobe.s3Load  = stageVal[1];
    strobe.s4Load  = stageVal[2];
    strobe.outLoad = stageVal[3];
    strobe.posWr   = tblWe && !tblSel;
    strobe.engWr   = tblWe && tblSel;
  end

  assign evtValid = stageVal[PIPE_DEPTH-1];

endmodule

// File: rtl/anger_qual_dp.sv
module anger_qual_dp
  import anger_qual_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned RATIO_W  = 6,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned TIME_W   = 16,
  localparam int unsigned E_W     = SAMPLE_W + 2,
  localparam int unsigned ADDR_W  = 2 * RATIO_W,
  localparam int unsigned DATA_W  = 2 * E_W
) (
  input  logic              clk,
  input  qualStrobe_t       strobe,
  input  logic [SAMPLE_W-1:0] inA,
  input  logic [SAMPLE_W-1:0] inB,
  input  logic [SAMPLE_W-1:0] inC,
  input  logic [SAMPLE_W-1:0] inD,
  input  logic [TIME_W-1:0] inTime,
  input  logic [ADDR_W-1:0] tblAddr,
  input  logic [DATA_W-1:0] tblData,
  output logic              eIsZero,
  output logic [ID_W-1:0]   evtCrystal,
  output logic              evtEnergyOk,
  output logic [E_W-1:0]    evtEnergy,
  output logic [TIME_W-1:0] evtTime
);

  localparam int unsigned POS_DEPTH = 1 << ADDR_W;
  localparam int unsigned ENG_DEPTH = 1 << ID_W;

  // Restoring fractional divide: floor(num * 2^RATIO_W / den), saturated
  function automatic logic [RATIO_W-1:0] fracCode(input logic [E_W-1:0] num,
                                                  input logic [E_W-1:0] den);
    logic [E_W:0] rem;
    logic [RATIO_W-1:0] code;
    if (num >= den) return '1;
    rem  = {1'b0, num};
    code = '0;
    for (int i = RATIO_W - 1; i >= 0; i--) begin
      rem = rem << 1;
      if (rem >= {1'b0, den}) begin
        code[i] = 1'b1;
        rem     = rem - {1'b0, den};
      end
    end
    return code;
  endfunction

  // Stage 0: sums
  logic [E_W-1:0] sumAll, sumTop, sumRight;
  assign sumAll   = E_W'(inA) + E_W'(inB) + E_W'(inC) + E_W'(inD);
  assign sumTop   = E_W'(inA) + E_W'(inB);
  assign sumRight = E_W'(inB) + E_W'(inD);
  assign eIsZero  = (sumAll == '0);

  // Stage 1 registers
  logic [E_W-1:0]    s1E, s1Top, s1Right;
  logic [TIME_W-1:0] s1Time;
  always_ff @(posedge clk) begin
    if (strobe.s1Load) begin
      s1E     <= sumAll;
      s1Top   <= sumTop;
      s1Right <= sumRight;
      s1Time  <= inTime;
    end
  end

  // Stage 2: ratio codes
  logic [RATIO_W-1:0] s2Qx, s2Qy;
  logic [E_W-1:0]     s2E;
  logic [TIME_W-1:0]  s2Time;
  always_ff @(posedge clk) begin
    if (strobe.s2Load) begin
      s2Qy   <= fracCode(s1Top, s1E);
      s2Qx   <= fracCode(s1Right, s1E);
      s2E    <= s1E;
      s2Time <= s1Time;
    end
  end

  // Stage 3: position table read
  logic [ID_W-1:0]   posMem [POS_DEPTH];
  logic [ID_W-1:0]   s3Id;
  logic [E_W-1:0]    s3E;
  logic [TIME_W-1:0] s3Time;
  always_ff @(posedge clk) begin
    if (strobe.posWr) posMem[tblAddr] <= tblData[ID_W-1:0];
    if (strobe.s3Load) begin
      s3Id   <= posMem[{s2Qy, s2Qx}];
      s3E    <= s2E;
      s3Time <= s2Time;
    end
  end

  // Stage 4: energy window read
  logic [DATA_W-1:0] engMem [ENG_DEPTH];
  logic [DATA_W-1:0] s4Win;
  logic [ID_W-1:0]   s4Id;
  logic [E_W-1:0]    s4E;
  logic [TIME_W-1:0] s4Time;
  always_ff @(posedge clk) begin
    if (strobe.engWr) engMem[tblAddr[ID_W-1:0]] <= tblData;
    if (strobe.s4Load) begin
      s4Win  <= engMem[s3Id];
      s4Id   <= s3Id;
      s4E    <= s3E;
      s4Time <= s3Time;
    end
  end

  // Stage 5: window compare and event record
  logic [E_W-1:0] winLo, winHi;
  assign winLo = s4Win[E_W-1:0];
  assign winHi = s4Win[DATA_W-1:E_W];

  always_ff @(posedge clk) begin
    if (strobe.outLoad) begin
      evtCrystal  <= s4Id;
      evtEnergyOk <= (s4E >= winLo) && (s4E <= winHi);
      evtEnergy   <= s4E;
      evtTime     <= s4Time;
    end
  end

endmodule

// File: rtl/anger_qualifier.sv
module anger_qualifier
  import anger_qual_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned RATIO_W  = 6,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned TIME_W   = 16,
  localparam int unsigned E_W     = SAMPLE_W + 2,
  localparam int unsigned ADDR_W  = 2 * RATIO_W,
  localparam int unsigned DATA_W  = 2 * E_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inVal,
  input  logic [SAMPLE_W-1:0] inA,
  input  logic [SAMPLE_W-1:0] inB,
  input  logic [SAMPLE_W-1:0] inC,
  input  logic [SAMPLE_W-1:0] inD,
  input  logic [TIME_W-1:0]   inTime,
  input  logic                tblWe,
  input  logic                tblSel,
  input  logic [ADDR_W-1:0]   tblAddr,
  input  logic [DATA_W-1:0]   tblData,
  output logic                evtValid,
  output logic [ID_W-1:0]     evtCrystal,
  output logic                evtEnergyOk,
  output logic [E_W-1:0]      evtEnergy,
  output logic [TIME_W-1:0]   evtTime
);

  qualStrobe_t strobe;
  logic        eIsZero;

  anger_qual_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inVal    (inVal),
    .eIsZero  (eIsZero),
    .tblWe    (tblWe),
    .tblSel   (tblSel),
    .strobe   (strobe),
    .evtValid (evtValid)
  );

  anger_qual_dp #(
    .SAMPLE_W (SAMPLE_W),
    .RATIO_W  (RATIO_W),
    .ID_W     (ID_W),
    .TIME_W   (TIME_W)
  ) u_dp (
    .clk         (clk),
    .strobe      (strobe),
    .inA         (inA),
    .inB         (inB),
    .inC         (inC),
    .inD         (inD),
    .inTime      (inTime),
    .tblAddr     (tblAddr),
    .tblData     (tblData),
    .eIsZero     (eIsZero),
    .evtCrystal  (evtCrystal),
    .evtEnergyOk (evtEnergyOk),
    .evtEnergy   (evtEnergy),
    .evtTime     (evtTime)
  );

endmodule

// File: rtl/anger_qual_chk.sv
module anger_qual_chk #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned TIME_W   = 16,
  localparam int unsigned E_W     = SAMPLE_W + 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                inVal,
  input logic [SAMPLE_W-1:0] inA,
  input logic [SAMPLE_W-1:0] inB,
  input logic [SAMPLE_W-1:0] inC,
  input logic [SAMPLE_W-1:0] inD,
  input logic [TIME_W-1:0]   inTime,
  input logic                evtValid,
  input logic [E_W-1:0]      evtEnergy,
  input logic [TIME_W-1:0]   evtTime
);

  logic [E_W-1:0] sumIn;
  logic           takeIn;
  logic [2:0]     sinceRst;
  logic           armed;

  assign sumIn  = E_W'(inA) + E_W'(inB) + E_W'(inC) + E_W'(inD);
  assign takeIn = inVal && (sumIn != '0);
  assign armed  = (sinceRst >= 3'd5);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  AST_EVENT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(takeIn, 5)) |-> evtValid); // R1

  AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(takeIn, 5)) |-> !evtValid); // R2

  AST_TIME_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(takeIn, 5)) |-> (evtTime == $past(inTime, 5))); // R5

  AST_ENERGY_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(takeIn, 5)) |-> (evtEnergy == $past(sumIn, 5))); // R6

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_IDLE: assert (!evtValid); // R7
    end
  end

endmodule

bind anger_qualifier anger_qual_chk #(
  .SAMPLE_W (SAMPLE_W),
  .TIME_W   (TIME_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inVal     (inVal),
  .inA       (inA),
  .inB       (inB),
  .inC       (inC),
  .inD       (inD),
  .inTime    (inTime),
  .evtValid  (evtValid),
  .evtEnergy (evtEnergy),
  .evtTime   (evtTime)
);

// File: tb/anger_qualifier_tb.sv
module anger_qualifier_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inVal = 1'b0;
  logic [11:0] inA = '0, inB = '0, inC = '0, inD = '0;
  logic [15:0] inTime = '0;
  logic        tblWe = 1'b0;
  logic        tblSel = 1'b0;
  logic [11:0] tblAddr = '0;
  logic [27:0] tblData = '0;
  logic        evtValid;
  logic [7:0]  evtCrystal;
  logic        evtEnergyOk;
  logic [13:0] evtEnergy;
  logic [15:0] evtTime;

  always #4 clk = ~clk;

  anger_qualifier u_dut (
    .clk(clk), .rstN(rstN), .inVal(inVal),
    .inA(inA), .inB(inB), .inC(inC), .inD(inD), .inTime(inTime),
    .tblWe(tblWe), .tblSel(tblSel), .tblAddr(tblAddr), .tblData(tblData),
    .evtValid(evtValid), .evtCrystal(evtCrystal), .evtEnergyOk(evtEnergyOk),
    .evtEnergy(evtEnergy), .evtTime(evtTime)
  );

  typedef struct {
    int          due;
    logic [7:0]  id;
    logic        ok;
    logic [13:0] e;
    logic [15:0] t;
  } expT;

  expT         pend[$];
  logic [7:0]  posTbl [4096];
  logic [13:0] loTbl [256];
  logic [13:0] hiTbl [256];
  int          cyc = 0;
  int          nChk = 0;
  int          nBad = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] refCode(input int num, input int den);
    int q;
    q = (num * 64) / den;
    return (q > 63) ? 6'd63 : 6'(q);
  endfunction

  function automatic logic [7:0] refPos(input int addr);
    return 8'((addr * 37 + 11) % 256);
  endfunction

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  task automatic checkOut;
    if (pend.size() > 0 && pend[0].due == cyc) begin
      expT x = pend.pop_front();
      nChk++;
      if (evtValid !== 1'b1) begin
        nBad++; $display("FAIL R1 evtValid act=%b exp=1 at cycle %0d", evtValid, cyc);
      end
      nChk++;
      if (evtCrystal !== x.id) begin
        nBad++; $display("FAIL R3 evtCrystal act=%0d exp=%0d", evtCrystal, x.id);
      end
      nChk++;
      if (evtEnergyOk !== x.ok) begin
        nBad++; $display("FAIL R4 evtEnergyOk act=%b exp=%b (E=%0d)", evtEnergyOk, x.ok, x.e);
      end
      nChk++;
      if (evtEnergy !== x.e) begin
        nBad++; $display("FAIL R6 evtEnergy act=%0d exp=%0d", evtEnergy, x.e);
      end
      nChk++;
      if (evtTime !== x.t) begin
        nBad++; $display("FAIL R5 evtTime act=%0d exp=%0d", evtTime, x.t);
      end
    end else begin
      nChk++;
      if (evtValid !== 1'b0) begin
        nBad++; $display("FAIL R2 unexpected evtValid act=%b exp=0 at cycle %0d", evtValid, cyc);
      end
    end
  endtask

  // One cycle: judge outputs at the falling edge, then drive the next inputs
  task automatic step(input logic v, input int a, input int b, input int c, input int d);
    int e;
    @(negedge clk);
    checkOut();
    tblWe  = 1'b0;
    inVal  = v;
    inA    = 12'(a); inB = 12'(b); inC = 12'(c); inD = 12'(d);
    inTime = 16'($urandom);
    e = a + b + c + d;
    if (v && e != 0) begin
      expT x;
      logic [5:0] qy, qx;
      qy   = refCode(a + b, e);
      qx   = refCode(b + d, e);
      x.id = posTbl[{qy, qx}];
      x.ok = (e >= int'(loTbl[x.id])) && (e <= int'(hiTbl[x.id]));
      x.e  = 14'(e);
      x.t  = inTime;
      x.due = cyc + 5;
      pend.push_back(x);
    end
  endtask

  task automatic writeTbl(input logic sel, input int addr, input logic [27:0] data);
    @(negedge clk);
    checkOut();
    inVal   = 1'b0;
    tblWe   = 1'b1;
    tblSel  = sel;
    tblAddr = 12'(addr);
    tblData = data;
    if (!sel) posTbl[addr] = data[7:0];
    else begin
      loTbl[addr % 256] = data[13:0];
      hiTbl[addr % 256] = data[27:14];
    end
  endtask

  task automatic setWin(input int id, input int lo, input int hi);
    writeTbl(1'b1, id, {14'(hi), 14'(lo)});
  endtask

  task automatic drain;
    for (int i = 0; i < 7; i++) step(1'b0, 0, 0, 0, 0);
  endtask

  initial begin
    int r;
    // Watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20110417));
    // Reset state (R7)
    repeat (3) @(negedge clk);
    nChk++;
    if (evtValid !== 1'b0) begin
      nBad++; $display("FAIL R7 evtValid during reset act=%b exp=0", evtValid);
    end
    rstN = 1'b1;

    // Program both tables (R8)
    for (int a = 0; a < 4096; a++) writeTbl(1'b0, a, 28'(refPos(a)));
    for (int i = 0; i < 256; i++) setWin(i, i * 40, i * 40 + 6000);
    drain();

    // Directed: saturated vertical ratio, zero horizontal (R3)
    step(1'b1, 900, 0, 0, 0);
    // Directed: full scale, both ratios at one half (R3, R6)
    step(1'b1, 4095, 4095, 4095, 4095);
    // Directed: zero energy dropped between two valid sets (R2)
    step(1'b1, 0, 0, 0, 0);
    step(1'b1, 10, 20, 30, 40);
    // Directed: smallest nonzero energy, both ratios saturate (R3)
    step(1'b1, 0, 1, 0, 0);
    drain();

    // Directed: inclusive window bounds with lo == hi == 1000 (R4)
    setWin(refPos(63 * 64), 1000, 1000);
    drain();
    step(1'b1, 999, 0, 0, 0);   // below: not ok
    step(1'b1, 1000, 0, 0, 0);  // equal both bounds: ok
    step(1'b1, 1001, 0, 0, 0);  // above: not ok
    drain();

    // Directed: rewrite a position entry, next event uses it (R8)
    writeTbl(1'b0, 63 * 64, 28'd201);
    step(1'b1, 500, 0, 0, 0);
    drain();

    // Constrained random, back-to-back with gaps (R1..R6)
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 15);
      if (sel == 0) step(1'b0, 0, 0, 0, 0);
      else if (sel == 1) step(1'b1, 0, 0, 0, 0);
      else if (sel == 2) step(1'b1, $urandom_range(0, 4095), $urandom_range(0, 4095), 0, 0);
      else step(1'b1, $urandom_range(0, 4095), $urandom_range(0, 4095),
                $urandom_range(0, 4095), $urandom_range(0, 4095));
    end
    drain();

    nChk++;
    if (pend.size() != 0) begin
      nBad++; $display("FAIL R1 events missing act=0 exp=%0d", pend.size());
    end
    done = 1'b1;
    report();
  end

endmodule